// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

This block is a clocked model of a byte-wide nonvolatile memory that a host drives like a static RAM. A request is formed from three strobes: chip enable, output enable and write enable. Reads return the stored byte one clock later. Writes are not programmed directly. Each written byte goes into a one-page staging buffer, which holds 64 bytes for the default page size. The host can write any number of bytes to the same page, and the buffer keeps the offset and data of each one. When the host stops writing for a set number of cycles, the block commits the buffer to storage on its own internal timer. The host does not need to keep driving the bus during this time.

There is no ready pin to show when a commit ends. The host polls with reads instead. While a commit runs, each read returns a status byte in place of data. The top bit of this status byte is the inverse of the top bit of the last byte staged. Bit 6 flips on every status read. When the commit ends, reads return real stored data again, so the polled top bit matches the written value. A separate 64-byte identification area sits beside the main array. It is selected by a side pin and uses the same staging and commit path.

The read response is a one-way stream: `rd_valid` is high for one cycle for each accepted read, and the stream has no back-pressure. The consumer must take `rd_data` in that cycle. Address width, page size, load window and commit time are parameters. The model defaults to an 11-bit address, and a full-size instance sets the address width to 13.

Top module: `eepg_ctrl`

## Requirements
- R1: After reset every byte of the main array and of the identification area reads 0xFF, and `rd_valid` is low.
- R2: A cycle with `ce`=1, `oe`=1, `we`=0 is a read: in the next cycle `rd_valid` is 1 and `rd_data` holds the addressed byte. A cycle that is not a read gives `rd_valid`=0 in the next cycle.
- R3: A cycle with `ce`=1 and `we`=1, outside a commit, stages `wdata` at offset `addr[5:0]` of the page `addr[ADDR_W-1:6]`. Stored data is unchanged until that commit ends, so reads before then return the old bytes.
- R4: After the last staged byte, the commit starts once LOAD_WIN cycles pass with no write. A write to the same page restarts this window.
- R5: A commit lasts PROG_CYC cycles. Reads accepted after it ends return the staged bytes.
- R6: A read accepted during a commit returns status: bit 7 is the inverse of bit 7 of the last staged byte, bit 6 flips on each such read (0 on the first after reset), and bits 5..0 are 0.
- R7: Offsets of the page that were not staged keep their previous stored value after the commit.
- R8: Writes presented during a commit are dropped and change no stored byte.
- R9: A write to a different page while staging starts the commit of the current page at once. That byte is held and becomes the first byte of a new burst when the commit ends.
- R10: With `id_sel`=1, reads and writes use the 64-byte identification area indexed by `addr[5:0]`. The page bits are ignored, and the main array is not touched.
- R11: When `we` and `oe` are both high with `ce`, the cycle is a write and produces no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Chip enable strobe |
| oe | input | 1 | Output enable strobe |
| we | input | 1 | Write enable strobe, takes priority over `oe` |
| id_sel | input | 1 | Selects the identification area instead of the main array |
| addr | input | ADDR_W | Byte address; low 6 bits are the offset within a page |
| wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle per read, no back-pressure |
| rd_data | output | 8 | Read response data or commit status |

## Verification
A wrong stage state shows up in two ways: a read-back after a commit returns a byte that was never written, or a byte that was written is missing. If the window or commit counter is off by one, a status byte appears one cycle early or late, and the first read that lands in that cycle shows it. A lost or duplicated pending byte after a page change shows up at the end of the second commit. The bench compares every response cycle with a behavioural model, so a wrong status toggle is caught on the very next status read.

// File: rtl/eepg_pkg.sv
package eepg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } eepg_state_t;
endpackage

// File: rtl/eepg_page_buf.sv
module eepg_page_buf #(
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ld_en,
  input  logic [OFF_W-1:0]                  ld_off,
  input  logic [DATA_W-1:0]                 ld_data,
  input  logic                              clr,
  output logic [(1<<OFF_W)-1:0]             mask,
  output logic [(1<<OFF_W)-1:0][DATA_W-1:0] bytes
);
  localparam int PAGE = 1 << OFF_W;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic              hit;
    logic              m_q;
    logic [DATA_W-1:0] d_q;

    assign hit = ld_en && (ld_off == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)   m_q <= 1'b0;
      else if (hit) m_q <= 1'b1;
      else if (clr) m_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (hit) d_q <= ld_data;
    end

    assign mask[g]  = m_q;
    assign bytes[g] = d_q;
  end

  // R7: a commit clears the set of staged offsets unless a new byte enters.
  assert_clear_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ld_en) |=> (mask == '0));

  // R3: a staged byte is marked present in the next cycle.
  assert_slot_marked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> mask[$past(ld_off)]);
endmodule

// File: rtl/eepg_timer.sv
module eepg_timer #(
  parameter int WIN  = 16,
  parameter int PROG = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic sel_prog,
  output logic expire
);
  localparam int LIM = (WIN > PROG) ? WIN : PROG;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;

  assign expire = sel_prog ? (cnt_q == CW'(PROG - 1)) : (cnt_q == CW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (run && !expire)   cnt_q <= cnt_q + 1'b1;
  end

  // R4: the load window never counts past its limit.
  assert_win_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel_prog) |-> (cnt_q <= CW'(LIM)));

  // R5: the commit counter never runs past the commit length.
  assert_prog_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel_prog) |-> (cnt_q <= CW'(PROG - 1)));
endmodule

// File: rtl/eepg_store.sv
module eepg_store #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 rd_addr,
  input  logic                              rd_id,
  output logic [DATA_W-1:0]                 rd_byte,
  input  logic                              commit_en,
  input  logic                              commit_id,
  input  logic [ADDR_W-OFF_W-1:0]           commit_page,
  input  logic [(1<<OFF_W)-1:0]             mask,
  input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] bytes
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << OFF_W;

  logic [DATA_W-1:0] main_q [DEPTH];
  logic [DATA_W-1:0] id_q   [PAGE];

  assign rd_byte = rd_id ? id_q[rd_addr[OFF_W-1:0]] : main_q[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
    end else if (commit_en && !commit_id) begin
      for (int i = 0; i < PAGE; i++) begin
        if (mask[i]) main_q[{commit_page, OFF_W'(i)}] <= bytes[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) id_q[i] <= '1;
    end else if (commit_en && commit_id) begin
      for (int i = 0; i < PAGE; i++) begin
        if (mask[i]) id_q[i] <= bytes[i];
      end
    end
  end
endmodule

// File: rtl/eepg_ctrl.sv
module eepg_ctrl
  import eepg_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int OFF_W    = 6,
  parameter int DATA_W   = 8,
  parameter int LOAD_WIN = 16,
  parameter int PROG_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              oe,
  input  logic              we,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAGE  = 1 << OFF_W;
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int KEY_W = PG_W + 1;

  eepg_state_t        st_q;
  logic [KEY_W-1:0]   key_q, key_in, pend_key_q;
  logic [OFF_W-1:0]   pend_off_q, ld_off;
  logic [DATA_W-1:0]  pend_d_q, ld_data, rd_byte, rd_data_q;
  logic               pend_v_q, last_b7_q, tgl_q, rd_valid_q;
  logic               wr_req, rd_req, busy, same_page;
  logic               wr_idle, wr_same, wr_foreign;
  logic               win_exp, go_commit, commit_done, ld_en, t_exp;
  logic [PAGE-1:0]              buf_mask;
  logic [PAGE-1:0][DATA_W-1:0]  buf_bytes;

  assign wr_req      = ce && we;
  assign rd_req      = ce && oe && !we;
  assign busy        = (st_q == ST_COMMIT);
  assign key_in      = {id_sel, id_sel ? {PG_W{1'b0}} : addr[ADDR_W-1:OFF_W]};
  assign same_page   = (key_in == key_q);
  assign wr_idle     = wr_req && (st_q == ST_IDLE);
  assign wr_same     = wr_req && (st_q == ST_LOAD) && same_page;
  assign wr_foreign  = wr_req && (st_q == ST_LOAD) && !same_page;
  assign win_exp     = (st_q == ST_LOAD) && !wr_req && t_exp;
  assign go_commit   = win_exp || wr_foreign;
  assign commit_done = busy && t_exp;
  assign ld_en       = wr_idle || wr_same || (commit_done && pend_v_q);
  assign ld_off      = commit_done ? pend_off_q : addr[OFF_W-1:0];
  assign ld_data     = commit_done ? pend_d_q   : wdata;

  eepg_page_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_off(ld_off),
    .ld_data(ld_data), .clr(commit_done), .mask(buf_mask), .bytes(buf_bytes)
  );

  eepg_timer #(.WIN(LOAD_WIN), .PROG(PROG_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(ld_en || go_commit),
    .run(st_q != ST_IDLE), .sel_prog(busy), .expire(t_exp)
  );

  eepg_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr), .rd_id(id_sel), .rd_byte(rd_byte),
    .commit_en(commit_done), .commit_id(key_q[KEY_W-1]),
    .commit_page(key_q[PG_W-1:0]), .mask(buf_mask), .bytes(buf_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   if (wr_req)    st_q <= ST_LOAD;
        ST_LOAD:   if (go_commit) st_q <= ST_COMMIT;
        ST_COMMIT: if (t_exp)     st_q <= pend_v_q ? ST_LOAD : ST_IDLE;
        default:                  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q      <= '0;
      pend_v_q   <= 1'b0;
      pend_key_q <= '0;
      pend_off_q <= '0;
      pend_d_q   <= '0;
      last_b7_q  <= 1'b0;
    end else begin
      if (wr_idle) key_q <= key_in;
      else if (commit_done && pend_v_q) key_q <= pend_key_q;
      if (wr_foreign) begin
        pend_v_q   <= 1'b1;
        pend_key_q <= key_in;
        pend_off_q <= addr[OFF_W-1:0];
        pend_d_q   <= wdata;
      end else if (commit_done) begin
        pend_v_q <= 1'b0;
      end
      if (ld_en) last_b7_q <= ld_data[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      tgl_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) begin
        if (busy) begin
          rd_data_q <= {~last_b7_q, tgl_q, {(DATA_W-2){1'b0}}};
          tgl_q     <= ~tgl_q;
        end else begin
          rd_data_q <= rd_byte;
        end
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R2: every read gets exactly one response cycle.
  assert_rd_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  assert_no_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R4: a same-page write keeps the burst open.
  assert_same_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_same |=> (st_q == ST_LOAD));
  // R5: commit completion leaves the busy state.
  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !busy);
  // R6: status polling inverts the top bit and flips the toggle bit.
  assert_poll_b7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy) |=> (rd_data[DATA_W-1] != $past(last_b7_q)));
  assert_poll_tgl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy) |=> (tgl_q != $past(tgl_q)));
  // R8: staged contents are frozen while a commit runs.
  assert_ignore_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !t_exp) |=> $stable(buf_mask));
  // R9: a foreign-page write starts a commit and holds its byte.
  assert_foreign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_foreign |=> (busy && pend_v_q));
  // R11: a write with output enable produces no response.
  assert_we_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && we && oe) |=> !rd_valid);
endmodule

// File: tb/sim_eepg_ctrl.sv
module sim_eepg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 11;
  localparam int LWIN = 8;
  localparam int PCYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 0, oe = 0, we = 0, id_sel = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rd_valid;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eepg_ctrl #(.ADDR_W(AW), .OFF_W(6), .DATA_W(8), .LOAD_WIN(LWIN), .PROG_CYC(PCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .oe(oe), .we(we), .id_sel(id_sel),
    .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Behavioural reference: time stamps and a sparse staged-page map.
  int m_main [1<<AW];
  int m_id   [64];
  int staged [int];
  int mode, burst_key, last_wr, c_start, cyc;
  int lastb7, tgl;
  int pend_v, pend_key, pend_off, pend_d;
  bit e_valid;
  int e_data;

  function automatic int key_of(bit id, int a);
    return id ? -1 : (a >> 6);
  endfunction

  task automatic open_burst(int k, int off, int d);
    staged.delete();
    staged[off] = d;
    burst_key = k;
    lastb7 = (d >> 7) & 1;
    last_wr = cyc;
    mode = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_main[i]) m_main[i] = 255;
      foreach (m_id[i]) m_id[i] = 255;
      staged.delete();
      mode = 0; cyc = 0; tgl = 0; lastb7 = 0; pend_v = 0;
      e_valid = 0; e_data = 0;
    end else begin
      bit wr, rd;
      int k;
      wr = ce && we;
      rd = ce && oe && !we;
      k = key_of(id_sel, addr);
      e_valid = rd;
      if (rd) begin
        if (mode == 2) begin
          e_data = ((lastb7 ^ 1) << 7) | (tgl << 6);
          tgl ^= 1;
        end else begin
          e_data = id_sel ? m_id[addr % 64] : m_main[addr];
        end
      end
      if (mode == 0) begin
        if (wr) open_burst(k, addr % 64, wdata);
      end else if (mode == 1) begin
        if (wr && k == burst_key) begin
          staged[addr % 64] = wdata;
          lastb7 = wdata[7];
          last_wr = cyc;
        end else if (wr) begin
          pend_v = 1; pend_key = k; pend_off = addr % 64; pend_d = wdata;
          mode = 2; c_start = cyc;
        end else if (cyc == last_wr + LWIN) begin
          mode = 2; c_start = cyc;
        end
      end else if (cyc == c_start + PCYC) begin
        foreach (staged[o]) begin
          if (burst_key < 0) m_id[o] = staged[o];
          else m_main[burst_key * 64 + o] = staged[o];
        end
        staged.delete();
        if (pend_v) begin
          pend_v = 0;
          open_burst(pend_key, pend_off, pend_d);
        end else begin
          mode = 0;
        end
      end
      cyc++;
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_valid !== e_valid || (e_valid && rd_data !== e_data[7:0])) begin
        errors++;
        $display("FAIL %s cycle compare: valid=%0b data=%02h expected valid=%0b data=%02h",
                 cur_req, rd_valid, rd_data, e_valid, e_data[7:0]);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, bit id, int d);
    @(negedge clk);
    ce = 1; we = 1; oe = 0; id_sel = id; addr = AW'(a); wdata = 8'(d);
    @(negedge clk);
    ce = 0; we = 0; id_sel = 0;
  endtask

  task automatic rd_chk(int a, bit id, int exp, string tag);
    @(negedge clk);
    ce = 1; oe = 1; we = 0; id_sel = id; addr = AW'(a);
    @(negedge clk);
    ce = 0; oe = 0; id_sel = 0;
    chk(tag, rd_valid ? int'(rd_data) : -1, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1;
    cur_req = "R1";
    chk("R1", int'(rd_valid), 0);
    rd_chk(0, 0, 8'hFF, "R1");
    rd_chk(2047, 0, 8'hFF, "R1");
    rd_chk(5, 1, 8'hFF, "R1");

    cur_req = "R3";
    wr(12'h085, 0, 8'h3C);
    wr(12'h086, 0, 8'hA1);
    wr(12'h080, 0, 8'h11);
    rd_chk(12'h085, 0, 8'hFF, "R3");
    idle(LWIN + 1);
    cur_req = "R6";
    rd_chk(12'h085, 0, 8'h80, "R6");
    rd_chk(12'h085, 0, 8'hC0, "R6");
    idle(PCYC);
    cur_req = "R5";
    rd_chk(12'h085, 0, 8'h3C, "R5");
    rd_chk(12'h086, 0, 8'hA1, "R5");
    rd_chk(12'h080, 0, 8'h11, "R5");
    cur_req = "R7";
    rd_chk(12'h081, 0, 8'hFF, "R7");
    rd_chk(12'h084, 0, 8'hFF, "R7");

    cur_req = "R4";
    wr(12'h100, 0, 8'h55);
    idle(LWIN - 3);
    wr(12'h101, 0, 8'h66);
    idle(LWIN - 3);
    rd_chk(12'h100, 0, 8'hFF, "R4");
    idle(LWIN + PCYC + 4);
    rd_chk(12'h100, 0, 8'h55, "R4");
    rd_chk(12'h101, 0, 8'h66, "R4");

    cur_req = "R8";
    wr(12'h200, 0, 8'h07);
    idle(LWIN + 2);
    wr(12'h201, 0, 8'h99);
    wr(12'h200, 0, 8'hEE);
    idle(PCYC + 4);
    rd_chk(12'h200, 0, 8'h07, "R8");
    rd_chk(12'h201, 0, 8'hFF, "R8");

    cur_req = "R9";
    wr(12'h300, 0, 8'hA5);
    wr(12'h340, 0, 8'h5A);
    rd_chk(12'h300, 0, 8'h00, "R9");
    idle(PCYC + 2);
    rd_chk(12'h300, 0, 8'hA5, "R9");
    rd_chk(12'h340, 0, 8'hFF, "R9");
    idle(LWIN + PCYC + 4);
    rd_chk(12'h340, 0, 8'h5A, "R9");

    cur_req = "R10";
    wr(12'h7C5, 1, 8'h42);
    wr(12'h003, 1, 8'h43);
    idle(LWIN + PCYC + 4);
    rd_chk(12'h005, 1, 8'h42, "R10");
    rd_chk(12'h7C3, 1, 8'h43, "R10");
    rd_chk(12'h7C5, 0, 8'hFF, "R10");
    rd_chk(12'h003, 0, 8'hFF, "R10");

    cur_req = "R11";
    @(negedge clk);
    ce = 1; we = 1; oe = 1; addr = AW'(12'h400); wdata = 8'h12;
    @(negedge clk);
    ce = 0; we = 0; oe = 0;
    chk("R11", int'(rd_valid), 0);
    idle(LWIN + PCYC + 4);
    rd_chk(12'h400, 0, 8'h12, "R11");

    cur_req = "R3";
    for (int o = 0; o < 64; o++) wr(12'h500 + o, 0, (o ^ 8'h5A) & 8'hFF);
    idle(LWIN + PCYC + 4);
    for (int o = 0; o < 64; o++) rd_chk(12'h500 + o, 0, (o ^ 8'h5A) & 8'hFF, "R3");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule